// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the software-visible control surface for a group of DMA channels. A processor reaches it over a simple 32-bit memory-mapped bus with a synchronous write strobe and a combinational read path. Every channel owns a 256-byte slice of the window, and channel n starts at byte offset n*0x100. Inside a slice the processor programs the 64-bit source and destination addresses, the access width and fixed-or-incrementing mode for each side, a request-line selector with an interval count, and a burst size with a burst count. The block presents all of these fields to a transfer engine as parallel configuration outputs.

A channel starts when software sets its request bit. The block then sends the engine a single-cycle start strobe. If software clears the bit while the transfer runs, the block sends a single-cycle stop strobe. The engine reports completion and errors with single-cycle pulses, and while it runs it holds an activity level. The busy status stays set until that level drops, so software can poll it to learn that an abort has really finished.

Completion and error latch into sticky raw flags. Software clears a flag by writing 1 to it. A second read-only register shows the flags ANDed with their enables, and the channel's interrupt line is the OR of that masked view. The number of channels is a parameter from 1 to 16.

Top module: `dmacr_top`

## Requirements
- R1: After reset, every register of every channel reads 0, every interrupt line is 0, and both engine strobes are 0.
- R2: The configuration words read back only their defined fields, and all other bits read 0. The defined fields are: offset 0x08 has interval [23:16] and request select [5:0]; offsets 0x10 and 0x14 (source and destination mode) have width code [25:24] and fixed-address flag [4]; offsets 0x18 and 0x1C hold the upper address words and 0x20 and 0x24 the lower ones, all 32 bits; offset 0x28 has burst size [25:0]; offset 0x2C has burst count [15:0]. Each field also appears on the matching configuration output.
- R3: Channel n answers at byte offsets n*0x100 to n*0x100+0xFF, and a write changes only the addressed channel. Undefined offsets, addresses whose two low bits are not 0, and channel indices at or above the channel count read 0 and ignore writes.
- R4: Writing 1 to bit 0 at offset 0x30 while that bit is 0 sets it and raises eng_start for exactly the one cycle after the write. Writing 1 while the bit is already set produces no strobe.
- R5: Writing 0 to bit 0 at offset 0x30 while that bit is set clears it and raises eng_stop for exactly the one cycle after the write. eng_start and eng_stop are never high together.
- R6: Bit 0 at offset 0x40 (busy) reads 1 while the request bit is set or the engine's activity input is high. After an abort it stays 1 until the activity input falls.
- R7: An eng_done pulse sets raw flag bit 0 and an eng_err pulse sets raw flag bit 1 (offset 0x44). Either pulse clears the request bit without producing eng_stop.
- R8: Writing 1 to a bit at offset 0x44 clears that flag, and writing 0 leaves it unchanged. If an engine event and a clearing write hit the same flag in the same cycle, the flag stays set.
- R9: Offset 0x48 reads the raw flags ANDed bit by bit with the enables. The channel's irq output is the OR of those two masked bits.
- R10: Offset 0x34 holds the enables (bit 0 for end of transfer, bit 1 for error) and reads back exactly what was written to those two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8+log2(NCH) | Byte address into the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_done | input | NCH | Per-channel completion pulse |
| eng_err | input | NCH | Per-channel error pulse |
| eng_active | input | NCH | Per-channel engine-running level |
| eng_start | output | NCH | Per-channel start strobe |
| eng_stop | output | NCH | Per-channel abort strobe |
| irq | output | NCH | Per-channel interrupt line |
| cfg_src_addr | output | NCH*64 | Source address per channel |
| cfg_dst_addr | output | NCH*64 | Destination address per channel |
| cfg_src_fixed | output | NCH | Source address does not increment |
| cfg_dst_fixed | output | NCH | Destination address does not increment |
| cfg_src_wcode | output | NCH*2 | Source access width code |
| cfg_dst_wcode | output | NCH*2 | Destination access width code |
| cfg_interval | output | NCH*8 | Interval count per channel |
| cfg_reqsel | output | NCH*6 | Request line select per channel |
| cfg_bsize | output | NCH*26 | Burst size per channel |
| cfg_bcount | output | NCH*16 | Burst count per channel |

## Verification
If the channel decode is wrong, the next readback sweep shows it: a value appears in a neighbouring slice, or a register loses its value. A wrong request bit shows up in the cycle right after the write that set or cleared it, as a missing, doubled or misplaced start or stop strobe. The flag state lives in two bits per channel and reaches the ports through the masked register and irq with no register in between. A lost event or a clearing write that wins when it should lose is therefore visible on the very next read.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;

  localparam int unsigned SLICE_AW   = 8;
  localparam int unsigned WIDX_W     = SLICE_AW - 2;
  localparam int unsigned BSIZE_W    = 26;
  localparam int unsigned BCOUNT_W   = 16;
  localparam int unsigned INTERVAL_W = 8;
  localparam int unsigned REQSEL_W   = 6;
  localparam int unsigned WCODE_W    = 2;
  localparam int unsigned NFLAG      = 2;

  // word indices inside a channel slice (byte offset / 4)
  localparam logic [WIDX_W-1:0] W_FACTOR = 6'h02;
  localparam logic [WIDX_W-1:0] W_SMODE  = 6'h04;
  localparam logic [WIDX_W-1:0] W_DMODE  = 6'h05;
  localparam logic [WIDX_W-1:0] W_SRC_HI = 6'h06;
  localparam logic [WIDX_W-1:0] W_DST_HI = 6'h07;
  localparam logic [WIDX_W-1:0] W_SRC_LO = 6'h08;
  localparam logic [WIDX_W-1:0] W_DST_LO = 6'h09;
  localparam logic [WIDX_W-1:0] W_BSIZE  = 6'h0A;
  localparam logic [WIDX_W-1:0] W_BCOUNT = 6'h0B;
  localparam logic [WIDX_W-1:0] W_START  = 6'h0C;
  localparam logic [WIDX_W-1:0] W_IEN    = 6'h0D;
  localparam logic [WIDX_W-1:0] W_STATUS = 6'h10;
  localparam logic [WIDX_W-1:0] W_RAW    = 6'h11;
  localparam logic [WIDX_W-1:0] W_MASKED = 6'h12;

  typedef struct packed {
    logic [INTERVAL_W-1:0] interval;
    logic [REQSEL_W-1:0]   reqsel;
    logic [31:0]           src_hi;
    logic [31:0]           src_lo;
    logic [31:0]           dst_hi;
    logic [31:0]           dst_lo;
    logic [WCODE_W-1:0]    src_w;
    logic                  src_fix;
    logic [WCODE_W-1:0]    dst_w;
    logic                  dst_fix;
    logic [BSIZE_W-1:0]    bsize;
    logic [BCOUNT_W-1:0]   bcount;
  } chan_cfg_t;

endpackage

// File: rtl/dmacr_rstsync.sv
module dmacr_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_sync_n = pipe_q[1];

endmodule

// File: rtl/dmacr_decode.sv
module dmacr_decode
  import dmacr_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned CH_IDX_W = 2,
  parameter int unsigned ADDR_W   = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic [NCH-1:0]    sel,
  output logic [NCH-1:0]    wr_sel,
  output logic [WIDX_W-1:0] widx
);

  logic [CH_IDX_W-1:0] ch_idx;
  logic                aligned;

  assign ch_idx  = addr[ADDR_W-1:SLICE_AW];
  assign aligned = (addr[1:0] == 2'b00);
  assign widx    = addr[SLICE_AW-1:2];

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign sel[i]    = aligned && (ch_idx == CH_IDX_W'(i));
    assign wr_sel[i] = wr && sel[i];
  end

endmodule

// File: rtl/dmacr_irq.sv
module dmacr_irq
  import dmacr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] clr_bits,
  input  logic [NFLAG-1:0] evt,
  input  logic [NFLAG-1:0] ien,
  output logic [NFLAG-1:0] raw,
  output logic [NFLAG-1:0] masked,
  output logic             irq
);

  logic [NFLAG-1:0] raw_q;
  logic [NFLAG-1:0] raw_d;
  logic             raw_ce;

  always_comb begin
    raw_d = raw_q;
    if (clr_we) raw_d = raw_d & ~clr_bits;
    raw_d  = raw_d | evt;           // a new event beats a same-cycle clear
    raw_ce = clr_we | (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_ce) raw_q <= raw_d;
  end

  assign raw    = raw_q;
  assign masked = raw_q & ien;
  assign irq    = |masked;

endmodule

// File: rtl/dmacr_chan.sv
module dmacr_chan
  import dmacr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] widx,
  input  logic [31:0]       wdata,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_active,
  output chan_cfg_t         cfg,
  output logic [31:0]       rdata,
  output logic              req,
  output logic [NFLAG-1:0]  raw,
  output logic              start_pls,
  output logic              stop_pls,
  output logic              irq
);

  chan_cfg_t        cfg_q, cfg_d;
  logic             cfg_we;
  logic [NFLAG-1:0] ien_q, ien_d;
  logic             ien_we;
  logic             req_q, req_d;
  logic             start_q, start_d;
  logic             stop_q, stop_d;
  logic             evt_any;
  logic [NFLAG-1:0] masked;
  logic             clr_we;

  // next state
  always_comb begin
    cfg_d  = cfg_q;
    cfg_we = 1'b0;
    if (wr_en) begin
      case (widx)
        W_FACTOR: begin
          cfg_d.interval = wdata[23:16];
          cfg_d.reqsel   = wdata[5:0];
          cfg_we         = 1'b1;
        end
        W_SMODE: begin
          cfg_d.src_w   = wdata[25:24];
          cfg_d.src_fix = wdata[4];
          cfg_we        = 1'b1;
        end
        W_DMODE: begin
          cfg_d.dst_w   = wdata[25:24];
          cfg_d.dst_fix = wdata[4];
          cfg_we        = 1'b1;
        end
        W_SRC_HI: begin cfg_d.src_hi = wdata; cfg_we = 1'b1; end
        W_DST_HI: begin cfg_d.dst_hi = wdata; cfg_we = 1'b1; end
        W_SRC_LO: begin cfg_d.src_lo = wdata; cfg_we = 1'b1; end
        W_DST_LO: begin cfg_d.dst_lo = wdata; cfg_we = 1'b1; end
        W_BSIZE:  begin cfg_d.bsize  = wdata[BSIZE_W-1:0];  cfg_we = 1'b1; end
        W_BCOUNT: begin cfg_d.bcount = wdata[BCOUNT_W-1:0]; cfg_we = 1'b1; end
        default:  cfg_we = 1'b0;
      endcase
    end

    ien_we = wr_en && (widx == W_IEN);
    ien_d  = wdata[NFLAG-1:0];
    clr_we = wr_en && (widx == W_RAW);

    evt_any = eng_done | eng_err;
    req_d   = req_q;
    if (wr_en && (widx == W_START)) req_d = wdata[0];
    if (evt_any) req_d = 1'b0;

    start_d = req_d & ~req_q;
    stop_d  = req_q & ~req_d & ~evt_any;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ien_q   <= '0;
      req_q   <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_d;
      if (ien_we) ien_q <= ien_d;
      req_q   <= req_d;
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end

  dmacr_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_we   (clr_we),
    .clr_bits (wdata[NFLAG-1:0]),
    .evt      ({eng_err, eng_done}),
    .ien      (ien_q),
    .raw      (raw),
    .masked   (masked),
    .irq      (irq)
  );

  // readback
  always_comb begin
    case (widx)
      W_FACTOR: rdata = {8'h00, cfg_q.interval, 10'h000, cfg_q.reqsel};
      W_SMODE:  rdata = {6'h00, cfg_q.src_w, 19'h00000, cfg_q.src_fix, 4'h0};
      W_DMODE:  rdata = {6'h00, cfg_q.dst_w, 19'h00000, cfg_q.dst_fix, 4'h0};
      W_SRC_HI: rdata = cfg_q.src_hi;
      W_DST_HI: rdata = cfg_q.dst_hi;
      W_SRC_LO: rdata = cfg_q.src_lo;
      W_DST_LO: rdata = cfg_q.dst_lo;
      W_BSIZE:  rdata = {{(32-BSIZE_W){1'b0}}, cfg_q.bsize};
      W_BCOUNT: rdata = {{(32-BCOUNT_W){1'b0}}, cfg_q.bcount};
      W_START:  rdata = {31'h0, req_q};
      W_IEN:    rdata = {{(32-NFLAG){1'b0}}, ien_q};
      W_STATUS: rdata = {31'h0, req_q | eng_active};
      W_RAW:    rdata = {{(32-NFLAG){1'b0}}, raw};
      W_MASKED: rdata = {{(32-NFLAG){1'b0}}, masked};
      default:  rdata = 32'h0;
    endcase
  end

  assign cfg       = cfg_q;
  assign req       = req_q;
  assign start_pls = start_q;
  assign stop_pls  = stop_q;

endmodule

// File: rtl/dmacr_top.sv
module dmacr_top
  import dmacr_pkg::*;
#(
  parameter  int unsigned NCH      = 4,
  localparam int unsigned CH_IDX_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned ADDR_W   = SLICE_AW + CH_IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NCH-1:0]          eng_done,
  input  logic [NCH-1:0]          eng_err,
  input  logic [NCH-1:0]          eng_active,
  output logic [NCH-1:0]          eng_start,
  output logic [NCH-1:0]          eng_stop,
  output logic [NCH-1:0]          irq,
  output logic [NCH*64-1:0]       cfg_src_addr,
  output logic [NCH*64-1:0]       cfg_dst_addr,
  output logic [NCH-1:0]          cfg_src_fixed,
  output logic [NCH-1:0]          cfg_dst_fixed,
  output logic [NCH*WCODE_W-1:0]  cfg_src_wcode,
  output logic [NCH*WCODE_W-1:0]  cfg_dst_wcode,
  output logic [NCH*INTERVAL_W-1:0] cfg_interval,
  output logic [NCH*REQSEL_W-1:0] cfg_reqsel,
  output logic [NCH*BSIZE_W-1:0]  cfg_bsize,
  output logic [NCH*BCOUNT_W-1:0] cfg_bcount
);

  logic              rst_sync_n;
  logic [NCH-1:0]    ch_sel;
  logic [NCH-1:0]    ch_wr;
  logic [WIDX_W-1:0] widx;
  logic [31:0]       ch_rdata [NCH];
  logic [NCH-1:0]    req_vec;
  logic [NCH*NFLAG-1:0] raw_vec;

  dmacr_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dmacr_decode #(
    .NCH      (NCH),
    .CH_IDX_W (CH_IDX_W),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .sel    (ch_sel),
    .wr_sel (ch_wr),
    .widx   (widx)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_cfg_t cfg;

    dmacr_chan u_ch (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_en      (ch_wr[i]),
      .widx       (widx),
      .wdata      (bus_wdata),
      .eng_done   (eng_done[i]),
      .eng_err    (eng_err[i]),
      .eng_active (eng_active[i]),
      .cfg        (cfg),
      .rdata      (ch_rdata[i]),
      .req        (req_vec[i]),
      .raw        (raw_vec[i*NFLAG +: NFLAG]),
      .start_pls  (eng_start[i]),
      .stop_pls   (eng_stop[i]),
      .irq        (irq[i])
    );

    assign cfg_src_addr[i*64 +: 64]              = {cfg.src_hi, cfg.src_lo};
    assign cfg_dst_addr[i*64 +: 64]              = {cfg.dst_hi, cfg.dst_lo};
    assign cfg_src_fixed[i]                      = cfg.src_fix;
    assign cfg_dst_fixed[i]                      = cfg.dst_fix;
    assign cfg_src_wcode[i*WCODE_W +: WCODE_W]   = cfg.src_w;
    assign cfg_dst_wcode[i*WCODE_W +: WCODE_W]   = cfg.dst_w;
    assign cfg_interval[i*INTERVAL_W +: INTERVAL_W] = cfg.interval;
    assign cfg_reqsel[i*REQSEL_W +: REQSEL_W]    = cfg.reqsel;
    assign cfg_bsize[i*BSIZE_W +: BSIZE_W]       = cfg.bsize;
    assign cfg_bcount[i*BCOUNT_W +: BCOUNT_W]    = cfg.bcount;
  end

  // AND-OR read mux across channel slices
  always_comb begin
    bus_rdata = 32'h0;
    for (int i = 0; i < NCH; i++) begin
      bus_rdata = bus_rdata | (ch_rdata[i] & {32{ch_sel[i]}});
    end
  end

endmodule

// File: rtl/dmacr_chk.sv
module dmacr_chk #(
  parameter int unsigned NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   req_vec,
  input logic [NCH*2-1:0] raw_vec,
  input logic [NCH-1:0]   eng_start,
  input logic [NCH-1:0]   eng_stop,
  input logic [NCH-1:0]   eng_done,
  input logic [NCH-1:0]   eng_err,
  input logic [NCH-1:0]   irq
);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start[i] |-> (req_vec[i] && !$past(req_vec[i]))); // R4
    AST_STOP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      eng_stop[i] |-> (!req_vec[i] && $past(req_vec[i]))); // R5
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_start[i] && eng_stop[i])); // R5
    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done[i] |=> raw_vec[i*2]); // R7
    AST_ERR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      eng_err[i] |=> raw_vec[i*2+1]); // R7
    AST_EVENT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done[i] || eng_err[i]) |=> (!req_vec[i] && !eng_stop[i])); // R7
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (raw_vec[i*2 +: 2] != 2'b00)); // R9
  end

endmodule

bind dmacr_top dmacr_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_vec   (req_vec),
  .raw_vec   (raw_vec),
  .eng_start (eng_start),
  .eng_stop  (eng_stop),
  .eng_done  (eng_done),
  .eng_err   (eng_err),
  .irq       (irq)
);

// File: tb/sim_dmacr_top.sv
`timescale 1ns/1ps
module sim_dmacr_top;
  localparam int NCH = 4;
  localparam int AW  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] eng_done = '0, eng_err = '0, eng_active = '0;
  logic [NCH-1:0] eng_start, eng_stop, irq;
  logic [NCH*64-1:0] cfg_src_addr, cfg_dst_addr;
  logic [NCH-1:0] cfg_src_fixed, cfg_dst_fixed;
  logic [NCH*2-1:0] cfg_src_wcode, cfg_dst_wcode;
  logic [NCH*8-1:0] cfg_interval;
  logic [NCH*6-1:0] cfg_reqsel;
  logic [NCH*26-1:0] cfg_bsize;
  logic [NCH*16-1:0] cfg_bcount;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dmacr_top #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_done(eng_done), .eng_err(eng_err), .eng_active(eng_active),
    .eng_start(eng_start), .eng_stop(eng_stop), .irq(irq),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_src_fixed(cfg_src_fixed), .cfg_dst_fixed(cfg_dst_fixed),
    .cfg_src_wcode(cfg_src_wcode), .cfg_dst_wcode(cfg_dst_wcode),
    .cfg_interval(cfg_interval), .cfg_reqsel(cfg_reqsel),
    .cfg_bsize(cfg_bsize), .cfg_bcount(cfg_bcount)
  );

  localparam logic [7:0] CFG_OFS [10] =
    '{8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h34};

  function automatic logic [31:0] fmask(input logic [7:0] ofs);
    case (ofs)
      8'h08: return 32'h00FF_003F;
      8'h10, 8'h14: return 32'h0300_0010;
      8'h18, 8'h1C, 8'h20, 8'h24: return 32'hFFFF_FFFF;
      8'h28: return 32'h03FF_FFFF;
      8'h2C: return 32'h0000_FFFF;
      8'h34: return 32'h0000_0003;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] pat(input int ch, input logic [7:0] ofs);
    return 32'hA5C3_0F96 ^ (ch * 32'h0101_0101) ^ ({26'b0, ofs[7:2]} * 32'h1357_9BDF);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, {32'h0, d}, {32'h0, exp});
  endtask

  task automatic evt(input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
    @(negedge clk);
    eng_done = dn; eng_err = er;
    @(negedge clk);
    eng_done = '0; eng_err = '0;
  endtask

  function automatic logic [AW-1:0] ad(input int ch, input logic [7:0] ofs);
    return AW'(ch * 256) + AW'(ofs);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int ch = 0; ch < NCH; ch++)
      for (int w = 0; w < 64; w++)
        rdchk("R1 reset readback", ad(ch, 8'(w * 4)), 32'h0);
    chk("R1 irq", {60'h0, irq}, 64'h0);
    chk("R1 strobes", {56'h0, eng_start, eng_stop}, 64'h0);

    // R2 R3 R10 sweep of configuration words over all channels
    for (int ch = 0; ch < NCH; ch++)
      for (int k = 0; k < 10; k++)
        wr(ad(ch, CFG_OFS[k]), pat(ch, CFG_OFS[k]));
    for (int ch = 0; ch < NCH; ch++)
      for (int k = 0; k < 10; k++)
        rdchk(CFG_OFS[k] == 8'h34 ? "R10 enable readback" : "R2 R3 readback",
              ad(ch, CFG_OFS[k]), pat(ch, CFG_OFS[k]) & fmask(CFG_OFS[k]));
    for (int ch = 0; ch < NCH; ch++) begin
      chk("R2 src addr out", cfg_src_addr[ch*64 +: 64], {pat(ch, 8'h18), pat(ch, 8'h20)});
      chk("R2 dst addr out", cfg_dst_addr[ch*64 +: 64], {pat(ch, 8'h1C), pat(ch, 8'h24)});
      chk("R2 bsize out", {38'h0, cfg_bsize[ch*26 +: 26]}, {32'h0, pat(ch, 8'h28) & 32'h03FF_FFFF});
      chk("R2 bcount out", {48'h0, cfg_bcount[ch*16 +: 16]}, {48'h0, pat(ch, 8'h2C) & 32'hFFFF});
      chk("R2 factor out", {50'h0, cfg_interval[ch*8 +: 8], cfg_reqsel[ch*6 +: 6]},
          {50'h0, pat(ch, 8'h08)[23:16], pat(ch, 8'h08)[5:0]});
      chk("R2 mode out", {58'h0, cfg_src_wcode[ch*2 +: 2], cfg_src_fixed[ch],
                          cfg_dst_wcode[ch*2 +: 2], cfg_dst_fixed[ch]},
          {58'h0, pat(ch, 8'h10)[25:24], pat(ch, 8'h10)[4], pat(ch, 8'h14)[25:24], pat(ch, 8'h14)[4]});
    end

    // R3 undefined offsets and misaligned writes
    for (int ch = 0; ch < NCH; ch++) begin
      wr(ad(ch, 8'h00), 32'hFFFF_FFFF);
      rdchk("R3 undefined offset", ad(ch, 8'h00), 32'h0);
      rdchk("R3 undefined offset", ad(ch, 8'h3C), 32'h0);
      rdchk("R3 undefined offset", ad(ch, 8'hFC), 32'h0);
      wr(ad(ch, 8'h21), 32'h1234_5678);
      rdchk("R3 misaligned ignored", ad(ch, 8'h20), pat(ch, 8'h20));
      rdchk("R3 misaligned reads 0", ad(ch, 8'h21), 32'h0);
    end
    for (int ch = 0; ch < NCH; ch++) wr(ad(ch, 8'h34), 32'h0);

    // R4 start strobe on channel 2
    wr(ad(2, 8'h30), 32'h1);
    chk("R4 start strobe", {60'h0, eng_start}, 64'h4);
    chk("R4 no stop", {60'h0, eng_stop}, 64'h0);
    @(negedge clk);
    chk("R4 strobe one cycle", {60'h0, eng_start}, 64'h0);
    rdchk("R4 request bit", ad(2, 8'h30), 32'h1);
    rdchk("R6 busy while requested", ad(2, 8'h40), 32'h1);
    wr(ad(2, 8'h30), 32'h1);
    chk("R4 no restart strobe", {60'h0, eng_start}, 64'h0);

    // R7 completion self-clears
    evt(4'b0100, 4'b0000);
    chk("R7 no stop on done", {60'h0, eng_stop}, 64'h0);
    rdchk("R7 request cleared", ad(2, 8'h30), 32'h0);
    rdchk("R7 end flag", ad(2, 8'h44), 32'h1);
    rdchk("R6 idle", ad(2, 8'h40), 32'h0);
    wr(ad(2, 8'h30), 32'h1);
    evt(4'b0000, 4'b0100);
    rdchk("R7 error flag", ad(2, 8'h44), 32'h3);
    rdchk("R7 request cleared by error", ad(2, 8'h30), 32'h0);
    rdchk("R3 neighbour flags", ad(1, 8'h44), 32'h0);

    // R8 write-1-to-clear
    wr(ad(2, 8'h44), 32'h0);
    rdchk("R8 zero write no effect", ad(2, 8'h44), 32'h3);
    wr(ad(2, 8'h44), 32'h2);
    rdchk("R8 clear error only", ad(2, 8'h44), 32'h1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ad(2, 8'h44); bus_wdata = 32'h1; eng_done = 4'b0100;
    @(negedge clk);
    bus_wr = 1'b0; eng_done = '0;
    rdchk("R8 event beats clear", ad(2, 8'h44), 32'h1);
    wr(ad(2, 8'h44), 32'h1);
    rdchk("R8 clear end", ad(2, 8'h44), 32'h0);

    // R9 masking sweep over all enable values with both flags set
    evt(4'b0100, 4'b0100);
    for (int e = 0; e < 4; e++) begin
      wr(ad(2, 8'h34), 32'(e));
      rdchk("R10 enable", ad(2, 8'h34), 32'(e));
      rdchk("R9 masked", ad(2, 8'h48), 32'(e));
      chk("R9 irq", {60'h0, irq}, (e != 0) ? 64'h4 : 64'h0);
    end
    wr(ad(2, 8'h44), 32'h2);
    rdchk("R9 masked after clear", ad(2, 8'h48), 32'h1);
    chk("R9 irq after clear", {60'h0, irq}, 64'h4);
    wr(ad(2, 8'h44), 32'h1);
    chk("R9 irq drops", {60'h0, irq}, 64'h0);

    // R5 R6 abort on channel 1
    wr(ad(1, 8'h30), 32'h1);
    chk("R4 start ch1", {60'h0, eng_start}, 64'h2);
    @(negedge clk);
    eng_active = 4'b0010;
    wr(ad(1, 8'h30), 32'h0);
    chk("R5 stop strobe", {60'h0, eng_stop}, 64'h2);
    chk("R5 no start with stop", {60'h0, eng_start}, 64'h0);
    rdchk("R5 request cleared", ad(1, 8'h30), 32'h0);
    rdchk("R6 busy until engine stops", ad(1, 8'h40), 32'h1);
    @(negedge clk);
    chk("R5 stop one cycle", {60'h0, eng_stop}, 64'h0);
    rdchk("R6 still busy", ad(1, 8'h40), 32'h1);
    eng_active = 4'b0000;
    rdchk("R6 idle after engine stop", ad(1, 8'h40), 32'h0);
    wr(ad(1, 8'h30), 32'h0);
    chk("R5 no stop when idle", {60'h0, eng_stop}, 64'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule